// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Set-Less-Than

This unit performs the single-cycle integer operations of a small load/store RISC core: wrapping add and subtract, the bitwise AND, OR and NOR functions, logical shifts by an immediate amount, signed and unsigned set-less-than, and a load-upper-immediate that places a 16-bit constant in the upper half of the word. The core's decoder supplies two 32-bit operands, a 5-bit shift amount and a 4-bit operation code. The unit returns a 32-bit result and a flag that is high when that result is zero. Branch-equal logic uses this flag after a subtract.

The result and flag can be captured in an output register, which loads only while the valid strobe is high. With `REG_OUT_EN = 1` (the default), each result appears one clock after the strobe and then holds until the next strobe. With `REG_OUT_EN = 0`, the path is purely combinational.

The unit has no dedicated operation for subtracting an immediate. The decoder adds a sign-extended negative constant instead. A full 32-bit constant is built by load-upper-immediate followed by an OR with the low half.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) returns a_i + b_i modulo 2^32; there is no overflow output.
- R2: Operation code 1 (subtract) returns a_i - b_i modulo 2^32; equal operands give a zero result with zero_o high.
- R3: Operation code 2 returns a_i AND b_i; operation code 3 returns a_i OR b_i.
- R4: Operation code 4 returns NOT(a_i OR b_i); with a_i zero this is the bitwise inverse of b_i.
- R5: Operation code 5 shifts b_i left by shamt_i (0..31) and fills with zeros; a_i has no effect.
- R6: Operation code 6 shifts b_i right by shamt_i and fills with zeros; a_i has no effect.
- R7: Operation code 7 returns 1 in bit 0 when a_i is less than b_i as two's-complement numbers, else 0; bits 31:1 are always zero.
- R8: Operation code 8 compares the operands as unsigned numbers, so 0xFFFFFFFF against 1 gives 0 (code 7 gives 1 for the same pair); bits 31:1 are zero.
- R9: Operation code 9 returns b_i[15:0] in bits 31:16 with bits 15:0 zero.
- R10: Operation codes 10 to 15 return a result of zero.
- R11: zero_o is high exactly when result_o is all zeros.
- R12: With the output register enabled, result_o, zero_o and valid_o appear on the clock after valid_i is high. While valid_i is low, result_o and zero_o hold, and valid_o is low. Reset clears result_o to 0, sets zero_o to 1 and clears valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands and operation are valid; loads the output register |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; shift source; immediate in bits 15:0 |
| shamt_i | input | 5 | Shift amount from the instruction |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |
| valid_o | output | 1 | Result registered this cycle |

## Verification
Each operation presented with valid_i high at the bench's falling-edge drive point is due at the next rising edge. Its result, flag and valid_o are therefore read on the following falling edge.

The driver pushes one expected item per strobe into a queue. The monitor pops an item only on a falling edge where valid_o is high, so a result cannot be compared against the wrong cycle.

To check hold behaviour, the bench changes every input with valid_i low and reads the held outputs one cycle later. The reset state is read before the first strobe.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/int_alu_arith.sv
module int_alu_arith #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] diff_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] sub_ext;

  assign sum_o   = a_i + b_i;
  // a + ~b + 1 with carry out; carry clear means borrow
  assign sub_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
  assign diff_o  = sub_ext[MSB:0];
  assign lt_u_o  = ~sub_ext[WIDTH];
  assign lt_s_o  = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : sub_ext[MSB];
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o,
  output logic [WIDTH-1:0] upper_o
);
  localparam int unsigned HALF = WIDTH / 2;

  assign and_o   = a_i & b_i;
  assign or_o    = a_i | b_i;
  assign nor_o   = ~(a_i | b_i);
  assign upper_o = {b_i[HALF-1:0], {(WIDTH-HALF){1'b0}}};
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SH_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SH_W-1:0]  amt_i,
  output logic [WIDTH-1:0] left_o,
  output logic [WIDTH-1:0] right_o
);
  logic [WIDTH-1:0] l_stg [SH_W+1];
  logic [WIDTH-1:0] r_stg [SH_W+1];

  assign l_stg[0] = val_i;
  assign r_stg[0] = val_i;

  // log2 barrel: stage k shifts by 2**k
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign l_stg[k+1] = amt_i[k] ? (l_stg[k] << (2**k)) : l_stg[k];
    assign r_stg[k+1] = amt_i[k] ? (r_stg[k] >> (2**k)) : r_stg[k];
  end

  assign left_o  = l_stg[SH_W];
  assign right_o = r_stg[SH_W];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned SH_W       = $clog2(WIDTH),
  parameter bit          REG_OUT_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             valid_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] sum_w, diff_w, and_w, or_w, nor_w, upper_w, sll_w, srl_w;
  logic             lt_s_w, lt_u_w;
  logic [WIDTH-1:0] res_d;
  logic             zero_d;

  int_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i(a_i), .b_i(b_i), .sum_o(sum_w), .diff_o(diff_w),
    .lt_s_o(lt_s_w), .lt_u_o(lt_u_w)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .and_o(and_w), .or_o(or_w),
    .nor_o(nor_w), .upper_o(upper_w)
  );

  int_alu_shift #(.WIDTH(WIDTH), .SH_W(SH_W)) u_shift (
    .val_i(b_i), .amt_i(shamt_i), .left_o(sll_w), .right_o(srl_w)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_d = sum_w;
      OP_SUB:  res_d = diff_w;
      OP_AND:  res_d = and_w;
      OP_OR:   res_d = or_w;
      OP_NOR:  res_d = nor_w;
      OP_SLL:  res_d = sll_w;
      OP_SRL:  res_d = srl_w;
      OP_SLT:  res_d = {{(WIDTH-1){1'b0}}, lt_s_w};
      OP_SLTU: res_d = {{(WIDTH-1){1'b0}}, lt_u_w};
      OP_LUI:  res_d = upper_w;
      default: res_d = '0;
    endcase
  end

  assign zero_d = (res_d == '0);

  if (REG_OUT_EN) begin : g_reg
    logic [WIDTH-1:0] res_q;
    logic             zero_q, valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q   <= '0;
        zero_q  <= 1'b1;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) begin
          res_q  <= res_d;
          zero_q <= zero_d;
        end
      end
    end

    assign result_o = res_q;
    assign zero_o   = zero_q;
    assign valid_o  = valid_q;

    // R12
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(result_o) && $stable(zero_o) && !valid_o));
    // R12
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    // R11
    zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_o == (result_o == '0));
    // R2
    sub_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_SUB && a_i == b_i) |=> zero_o);
    // R7
    slt_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (op_i == OP_SLT || op_i == OP_SLTU)) |=> (result_o[WIDTH-1:1] == '0));
    // R9
    lui_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_LUI) |=> (result_o[HALF-1:0] == '0));
    // R10
    unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i > OP_LUI) |=> (result_o == '0 && zero_o));
    // R5
    sll_zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_SLL && shamt_i == '0) |=> (result_o == $past(b_i)));
  end else begin : g_comb
    assign result_o = res_d;
    assign zero_o   = zero_d;
    assign valid_o  = valid_i;
  end
endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         zero;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic [4:0]   shamt = '0;
  logic [W-1:0] result;
  logic         zero, vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  int_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .shamt_i(shamt),
    .result_o(result), .zero_o(zero), .valid_o(vld_o)
  );

  function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                        input logic [W-1:0] y, input logic [4:0] s);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return y << s;
      4'd6: return y >> s;
      4'd7: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd8: return (x < y) ? 32'd1 : 32'd0;
      4'd9: return {y[15:0], 16'h0};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic [4:0] s);
    exp_t e;
    @(negedge clk);
    valid = 1'b1; op = o; a = x; b = y; shamt = s;
    e.res  = model(o, x, y, s);
    e.zero = (e.res == '0);
    e.req  = req;
    q.push_back(e);
  endtask

  // monitor: compare one cycle after each strobe
  always @(negedge clk) begin
    if (rst_n && vld_o) begin
      if (q.size() == 0) begin
        check("R12", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, result, e.res);
        check("R11", {31'd0, zero}, {31'd0, e.zero});
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", result, 32'd0);
    check("R12", {31'd0, zero}, 32'd1);
    check("R12", {31'd0, vld_o}, 32'd0);

    drive("R1",  4'd0, 32'hFFFF_FFFF, 32'd2, 5'd0);
    drive("R1",  4'd0, 32'h1234_5678, 32'h0101_0101, 5'd3);
    drive("R2",  4'd1, 32'd5, 32'd7, 5'd0);
    drive("R2",  4'hA, 32'd0, 32'd0, 5'd0);
    drive("R2",  4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0);
    drive("R3",  4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0);
    drive("R3",  4'd3, 32'hF000_0001, 32'h0F00_0010, 5'd0);
    drive("R4",  4'd4, 32'h0, 32'h00FF_00FF, 5'd0);
    drive("R4",  4'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0);
    drive("R5",  4'd5, 32'hFFFF_FFFF, 32'h8000_0003, 5'd1);
    drive("R5",  4'd5, 32'h0, 32'h0000_0005, 5'd31);
    drive("R5",  4'd5, 32'h1234, 32'hCAFE_F00D, 5'd0);
    drive("R6",  4'd6, 32'hFFFF_FFFF, 32'h8000_0000, 5'd31);
    drive("R6",  4'd6, 32'h0, 32'hF000_000F, 5'd4);
    drive("R7",  4'd7, 32'hFFFF_FFFF, 32'd1, 5'd0);
    drive("R7",  4'd7, 32'd1, 32'hFFFF_FFFF, 5'd0);
    drive("R7",  4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    drive("R7",  4'd7, 32'd9, 32'd9, 5'd0);
    drive("R8",  4'd8, 32'hFFFF_FFFF, 32'd1, 5'd0);
    drive("R8",  4'd8, 32'd1, 32'hFFFF_FFFF, 5'd0);
    drive("R9",  4'd9, 32'hFFFF_FFFF, 32'hABCD_1234, 5'd7);
    for (int k = 10; k < 16; k++) drive("R10", 4'(k), 32'hFFFF_FFFF, 32'h1357_9BDF, 5'd5);
    drive("R9",  4'd9, 32'h0, 32'h0000_8001, 5'd0);

    @(negedge clk);
    valid = 1'b0; op = 4'd0; a = 32'h1; b = 32'h1; shamt = 5'd2;
    @(negedge clk);
    held = result;
    // R12: inputs change with valid low; outputs must hold
    check("R12", held, 32'h8001_0000);
    check("R12", {31'd0, vld_o}, 32'd0);
    @(negedge clk);
    op = 4'd3; a = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R12", result, held);
    check("R12", {31'd0, zero}, 32'd0);
    check("R12", {W{1'b0}} + q.size(), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule